// File: doc/BRIEF.md
# Serial EEPROM Fill-All Engine

This block is the device-side logic of a three-wire serial EEPROM: a chip select, a serial clock and a serial data input, plus one serial output that can be released to high impedance. It decodes a fill command that writes one 16-bit data word into every location of a small on-chip array. It also decodes the enable and disable commands that gate writing. The serial pins are sampled by a fast system clock, and edges of the serial clock and of chip select are found by comparing each sample with the one before.

A fill runs as a self-timed cycle that needs no further serial clocks once it has started. The cycle first clears every word to all ones and then programs every word with the supplied data. It keeps the engine busy for a fixed, parameterised number of system clocks. A parameter selects the trigger: the falling edge of chip select after the final data bit, or the serial clock rising edge that samples that bit.

After a cycle has been launched, the host can poll progress on the serial output. It lowers chip select for at least a minimum time and then raises it. The output then reads low while busy and high when ready. A bare start bit followed by chip select going low withdraws this indication. A registered read port lets the surrounding logic inspect the array contents.

Top module: `mw_wral_engine`

## Requirements
- R1: When a fill cycle completes, every one of the 2^ADDR_W array words reads back as the data word carried by the command.
- R2: Once launched, the cycle first writes all ones to word 0, then to each following word, and only then programs the data word into each word in turn. The engine stays busy for exactly PROG_CYCLES system clocks, starting two clocks after the clock edge that sees the trigger.
- R3: A fill command received while writing is disabled has no effect: the array keeps its contents and no busy cycle and no status report follow.
- R4: A frame is clocked in MSB first on serial-clock rising edges while chip select is high. It consists of a start bit of 1, a 2-bit opcode, ADDR_W address bits and, for a fill, DATA_W data bits. A fill uses opcode 00 with address bits [ADDR_W-1:ADDR_W-2] = 01.
- R5: Opcode 00 with top address bits 11 enables writing, and opcode 00 with top address bits 00 disables it. Writing is disabled after reset.
- R6: With TRIG_ON_CLK = 0, the cycle starts only when chip select falls after the final data bit. If chip select falls earlier, the frame is dropped, and completed data alone does not start anything.
- R7: With TRIG_ON_CLK = 1, the cycle starts from the serial-clock rise that samples the final data bit, while chip select is still high, and runs to its end without further serial clocks.
- R8: Consider chip select rising after at least CSL_CYC clocks low, where CSL_CYC = ceil(CSL_NS / CLK_NS) = 13 by default. If a cycle has been launched since the last clear, the output enable goes high one clock after the rise and the output reads 0 while busy and 1 when ready. After a shorter low time, or when chip select is low, the output is released.
- R9: A start bit that does not complete a command, followed by chip select going low, removes the status indication. Later chip-select rises leave the output released.
- R10: Frames clocked in while a cycle is busy are ignored, including enable and disable commands.
- R11: The read port returns the word at the address presented one clock earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_sel | input | 1 | Serial chip select, active high |
| ser_clk | input | 1 | Serial clock, data sampled on its rising edge |
| ser_in | input | 1 | Serial command and data input |
| ser_out | output | 1 | Status bit: 0 busy, 1 ready |
| ser_out_en | output | 1 | Output enable for ser_out; 0 means high impedance |
| rd_addr | input | ADDR_W | Array inspection address |
| rd_data | output | DATA_W | Array word, one clock after rd_addr |

## Verification
Each serial-clock or chip-select edge is seen at the first system clock after the bench moves the pin. The busy flag then appears two clocks after that edge and lasts exactly PROG_CYCLES clocks. The output enable follows a chip-select rise by one clock, and read data follows its address by one clock. The bench moves every pin on the falling system-clock edge and samples on the next falling edge. A behavioural model is compared with both trigger variants on every falling edge, so each of these delays is checked at the exact clock where it is due. The intermediate erase contents are read at a clock chosen inside the programming sweep, when the last word must still be all ones and the first word must already hold the data.

// File: rtl/mw_wral_pkg.sv
package mw_wral_pkg;
  // opcode shared by fill, enable and disable
  localparam logic [1:0] OP_SPECIAL = 2'b00;

  // top two address bits select the special command
  typedef enum logic [1:0] {
    SEL_DIS   = 2'b00,
    SEL_FILL  = 2'b01,
    SEL_OTHER = 2'b10,
    SEL_EN    = 2'b11
  } sel_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_ERASE,
    PH_PROG,
    PH_HOLD
  } phase_e;
endpackage

// File: rtl/mw_frame_rx.sv
module mw_frame_rx
  import mw_wral_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter bit TRIG_ON_CLK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel,
  input  logic              cs_fall,
  input  logic              sclk_rise,
  input  logic              ser_in,
  input  logic              busy,
  output logic              launch,
  output logic [DATA_W-1:0] fill_word,
  output logic              ewen,
  output logic              open_frame
);
  localparam int CMD_BITS = 2 + ADDR_W;
  localparam int FRAME_W  = CMD_BITS + DATA_W;
  localparam int CNT_W    = $clog2(FRAME_W + 1);
  localparam int SH_W     = (DATA_W > CMD_BITS) ? DATA_W - 1 : CMD_BITS - 1;

  logic             started, done, armed;
  logic [CNT_W-1:0] cnt;
  logic [SH_W-1:0]  sreg;
  logic [1:0]       op;
  sel_e             sel;

  // bits already shifted in, examined with the last command bit on the wire
  assign op  = sreg[CMD_BITS-2 -: 2];
  assign sel = sel_e'(sreg[ADDR_W-2 -: 2]);
  assign open_frame = started & ~done;

  always_ff @(posedge clk) begin
    launch <= 1'b0;
    if (rst) begin
      started   <= 1'b0;
      done      <= 1'b0;
      armed     <= 1'b0;
      cnt       <= '0;
      sreg      <= '0;
      ewen      <= 1'b0;
      fill_word <= '0;
    end else if (!chip_sel) begin
      if (cs_fall && armed) launch <= 1'b1;
      started <= 1'b0;
      done    <= 1'b0;
      armed   <= 1'b0;
      cnt     <= '0;
    end else if (sclk_rise && !busy) begin
      if (!started) begin
        started <= ser_in;
        cnt     <= '0;
      end else if (!done) begin
        sreg <= {sreg[SH_W-2:0], ser_in};
        cnt  <= cnt + 1'b1;
        if (cnt == CNT_W'(CMD_BITS - 1)) begin
          if (op != OP_SPECIAL) begin
            done <= 1'b1;
          end else begin
            case (sel)
              SEL_EN:   begin ewen <= 1'b1; done <= 1'b1; end
              SEL_DIS:  begin ewen <= 1'b0; done <= 1'b1; end
              SEL_FILL: ;
              default:  done <= 1'b1;
            endcase
          end
        end
        if (cnt == CNT_W'(FRAME_W - 1)) begin
          done <= 1'b1;
          if (ewen) begin
            fill_word <= {sreg[DATA_W-2:0], ser_in};
            if (TRIG_ON_CLK) launch <= 1'b1;
            else             armed  <= 1'b1;
          end
        end
      end
    end
  end

  // R3
  fill_needs_enable_chk: assert property (@(posedge clk) disable iff (rst)
    launch |-> ewen);

  generate
    if (!TRIG_ON_CLK) begin : g_cs_trig
      // R6
      cs_trigger_low_chk: assert property (@(posedge clk) disable iff (rst)
        launch |-> !chip_sel);
    end
  endgenerate
endmodule

// File: rtl/mw_fill_seq.sv
module mw_fill_seq
  import mw_wral_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [DATA_W-1:0] fill_word,
  output logic              busy,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  // PROG_CYCLES must be at least twice the word count
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [ADDR_W-1:0] LAST_IDX = {ADDR_W{1'b1}};
  localparam logic [CNT_W-1:0]  END_CNT  = CNT_W'(PROG_CYCLES - 1);

  phase_e            ph;
  logic [ADDR_W-1:0] idx;
  logic [CNT_W-1:0]  tcnt;
  logic [DATA_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph     <= PH_IDLE;
      idx    <= '0;
      tcnt   <= '0;
      word_q <= '0;
    end else begin
      case (ph)
        PH_IDLE: if (launch) begin
          ph     <= PH_ERASE;
          idx    <= '0;
          tcnt   <= '0;
          word_q <= fill_word;
        end
        PH_ERASE: begin
          tcnt <= tcnt + 1'b1;
          idx  <= idx + 1'b1;
          if (idx == LAST_IDX) ph <= PH_PROG;
        end
        PH_PROG: begin
          tcnt <= tcnt + 1'b1;
          idx  <= idx + 1'b1;
          if (idx == LAST_IDX) ph <= (tcnt == END_CNT) ? PH_IDLE : PH_HOLD;
        end
        PH_HOLD: begin
          tcnt <= tcnt + 1'b1;
          if (tcnt == END_CNT) ph <= PH_IDLE;
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  assign busy    = (ph != PH_IDLE);
  assign wr_en   = (ph == PH_ERASE) || (ph == PH_PROG);
  assign wr_addr = idx;
  assign wr_data = (ph == PH_ERASE) ? '1 : word_q;
endmodule

// File: rtl/mw_array.sv
module mw_array #(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int WORDS = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [0:WORDS-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mw_status.sv
module mw_status #(
  parameter int CSL_CYC = 13
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_sel,
  input  logic cs_rise,
  input  logic cs_fall,
  input  logic launch,
  input  logic busy,
  input  logic open_frame,
  output logic drive
);
  localparam int LC_W = $clog2(CSL_CYC + 1);
  localparam logic [LC_W-1:0] LC_MAX = LC_W'(CSL_CYC);

  logic [LC_W-1:0] lowcnt;
  logic            show, report;

  always_ff @(posedge clk) begin
    if (rst) begin
      lowcnt <= '0;
      show   <= 1'b0;
      report <= 1'b0;
    end else begin
      if (!chip_sel) begin
        show <= 1'b0;
        if (lowcnt != LC_MAX) lowcnt <= lowcnt + 1'b1;
      end else begin
        lowcnt <= '0;
        if (cs_rise && lowcnt == LC_MAX) show <= 1'b1;
      end
      if (launch)                                report <= 1'b1;
      else if (cs_fall && open_frame && !busy)   report <= 1'b0;
    end
  end

  assign drive = show & report;

  // R8
  release_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_sel |=> !drive);

  // R9
  start_clears_chk: assert property (@(posedge clk) disable iff (rst)
    (cs_fall && open_frame && !busy && !launch) |=> !report);
endmodule

// File: rtl/mw_wral_engine.sv
module mw_wral_engine #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 6,
  parameter int PROG_CYCLES = 200,
  parameter int CLK_NS      = 20,
  parameter int CSL_NS      = 250,
  parameter bit TRIG_ON_CLK = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chip_sel,
  input  logic              ser_clk,
  input  logic              ser_in,
  output logic              ser_out,
  output logic              ser_out_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int CSL_CYC = (CSL_NS + CLK_NS - 1) / CLK_NS;

  logic cs_d, sclk_d;
  logic cs_rise, cs_fall, sclk_rise;
  logic launch, ewen, open_frame, busy, drive;
  logic wr_en;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data, fill_word;

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d   <= 1'b0;
      sclk_d <= 1'b0;
    end else begin
      cs_d   <= chip_sel;
      sclk_d <= ser_clk;
    end
  end

  assign cs_rise   = chip_sel & ~cs_d;
  assign cs_fall   = ~chip_sel & cs_d;
  assign sclk_rise = ser_clk & ~sclk_d;

  mw_frame_rx #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TRIG_ON_CLK(TRIG_ON_CLK)) u_rx (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .cs_fall(cs_fall),
    .sclk_rise(sclk_rise), .ser_in(ser_in), .busy(busy), .launch(launch),
    .fill_word(fill_word), .ewen(ewen), .open_frame(open_frame)
  );

  mw_fill_seq #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .PROG_CYCLES(PROG_CYCLES)) u_seq (
    .clk(clk), .rst(rst), .launch(launch), .fill_word(fill_word), .busy(busy),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  mw_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(rd_data)
  );

  mw_status #(.CSL_CYC(CSL_CYC)) u_stat (
    .clk(clk), .rst(rst), .chip_sel(chip_sel), .cs_rise(cs_rise),
    .cs_fall(cs_fall), .launch(launch), .busy(busy),
    .open_frame(open_frame), .drive(drive)
  );

  assign ser_out    = ~busy;
  assign ser_out_en = drive;

  // R2
  erase_first_chk: assert property (@(posedge clk) disable iff (rst)
    launch |=> (busy && wr_en && wr_addr == '0 && wr_data == '1));

  // R10
  no_launch_busy_chk: assert property (@(posedge clk) disable iff (rst)
    busy |-> !launch);
endmodule

// File: tb/mw_wral_engine_test.sv
module mw_ref_model #(
  parameter bit MODE_B = 1'b0,
  parameter int P      = 200,
  parameter int CSL    = 13,
  parameter int AW     = 6,
  parameter int DW     = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic cs,
  input  logic sclk,
  input  logic di,
  output logic exp_oe,
  output logic exp_do
);
  int left, lowc;
  bit show, report, started, done, armed, ewen, pend, cs_p, sclk_p;
  bit busy_now, rise, cfall, crise, fire;
  bit q[$];

  initial begin exp_oe = 1'b0; exp_do = 1'b1; end

  always @(posedge clk) begin
    if (rst) begin
      left = 0; lowc = 0; show = 0; report = 0; started = 0; done = 0;
      armed = 0; ewen = 0; pend = 0; cs_p = 0; sclk_p = 0; q.delete();
      exp_oe = 1'b0; exp_do = 1'b1;
    end else begin
      busy_now = (left > 0);
      rise  = sclk && !sclk_p;
      cfall = !cs && cs_p;
      crise = cs && !cs_p;
      fire  = pend;
      pend  = 0;
      if (crise && lowc >= CSL) show = 1;
      if (!cs) begin show = 0; if (lowc < CSL) lowc++; end
      else lowc = 0;
      if (fire) report = 1;
      else if (cfall && started && !done && !busy_now) report = 0;
      if (!cs) begin
        if (cfall && armed) pend = 1;
        started = 0; done = 0; armed = 0; q.delete();
      end else if (rise && !busy_now) begin
        if (!started) started = di;
        else if (!done) begin
          q.push_back(di);
          if (q.size() == 2 + AW) begin
            if (q[0] || q[1]) done = 1;
            else if (q[2] && q[3]) begin ewen = 1; done = 1; end
            else if (!q[2] && !q[3]) begin ewen = 0; done = 1; end
            else if (q[2]) done = 1;
          end
          if (q.size() == 2 + AW + DW) begin
            done = 1;
            if (ewen) begin if (MODE_B) pend = 1; else armed = 1; end
          end
        end
      end
      if (left > 0) left--;
      if (fire) left = P;
      cs_p = cs; sclk_p = sclk;
      exp_oe = show && report;
      exp_do = !(left > 0);
    end
  end
endmodule

module mw_wral_engine_test;
  logic clk = 1'b0, rst = 1'b1, cs = 1'b0, sclk = 1'b0, di = 1'b0;
  logic [5:0]  rd_addr = '0;
  logic        so_a, soe_a, so_b, soe_b, eo_a, ed_a, eo_b, ed_b;
  logic [15:0] rd_a, rd_b;
  int checks = 0, errors = 0;
  bit run_cmp = 1'b0, ended = 1'b0;

  always #10 clk = ~clk;

  mw_wral_engine uut (
    .clk(clk), .rst(rst), .chip_sel(cs), .ser_clk(sclk), .ser_in(di),
    .ser_out(so_a), .ser_out_en(soe_a), .rd_addr(rd_addr), .rd_data(rd_a));

  mw_wral_engine #(.TRIG_ON_CLK(1'b1)) uut_b (
    .clk(clk), .rst(rst), .chip_sel(cs), .ser_clk(sclk), .ser_in(di),
    .ser_out(so_b), .ser_out_en(soe_b), .rd_addr(rd_addr), .rd_data(rd_b));

  mw_ref_model #(.MODE_B(1'b0)) ref_a (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .exp_oe(eo_a), .exp_do(ed_a));
  mw_ref_model #(.MODE_B(1'b1)) ref_b (
    .clk(clk), .rst(rst), .cs(cs), .sclk(sclk), .di(di), .exp_oe(eo_b), .exp_do(ed_b));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  // R8 per-clock comparison of status output against the model
  always @(negedge clk) if (run_cmp) begin
    chk(soe_a === eo_a && so_a === ed_a, "R8 status (cs trigger)", {so_a, soe_a}, {ed_a, eo_a});
    chk(soe_b === eo_b && so_b === ed_b, "R8 status (clk trigger)", {so_b, soe_b}, {ed_b, eo_b});
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input bit b);
    di = b; sclk = 1'b0;
    @(negedge clk);
    sclk = 1'b1;
    @(negedge clk);
    sclk = 1'b0;
  endtask

  // R4 frame: start, opcode, address, then the top ndata data bits
  task automatic send(input logic [1:0] op, input logic [5:0] addr, input int ndata, input logic [15:0] d);
    cs = 1'b1;
    bit_out(1'b1);
    for (int i = 1; i >= 0; i--) bit_out(op[i]);
    for (int i = 5; i >= 0; i--) bit_out(addr[i]);
    for (int i = 15; i > 15 - ndata; i--) bit_out(d[i]);
  endtask

  task automatic cs_low(input int n);
    cs = 1'b0;
    tick(n);
  endtask

  task automatic check_fill(input logic [15:0] ea, input logic [15:0] eb, input string req);
    for (int a = 0; a < 64; a++) begin
      rd_addr = 6'(a);
      @(negedge clk);
      chk(rd_a === ea, req, rd_a, ea);
      chk(rd_b === eb, req, rd_b, eb);
    end
  endtask

  initial begin
    tick(5);
    rst = 1'b0;
    run_cmp = 1'b1;
    tick(2);
    chk(soe_a === 1'b0 && soe_b === 1'b0, "reset released", {soe_a, soe_b}, 0);

    // R5: disabled after reset, so this fill is ignored
    send(2'b00, 6'b010000, 16, 16'h1111);
    cs_low(20); cs = 1'b1; tick(2);
    chk(soe_a === 1'b0 && soe_b === 1'b0, "R5 no report while disabled", {soe_a, soe_b}, 0);
    cs_low(20);

    send(2'b00, 6'b110000, 0, 16'h0);   // enable
    cs_low(20);
    send(2'b00, 6'b010000, 16, 16'h1234);
    cs_low(20); cs = 1'b1; tick(2);
    chk(soe_a === 1'b1 && so_a === 1'b0, "R8 busy reported", {so_a, soe_a}, 2'b01);
    for (int n = 0; n < 400 && so_a !== 1'b1; n++) tick(1);
    chk(so_a === 1'b1 && so_b === 1'b1, "R8 ready reported", {so_a, so_b}, 2'b11);
    check_fill(16'h1234, 16'h1234, "R1 fill contents");

    // R9: bare start bit then chip select low
    bit_out(1'b1);
    cs_low(20); cs = 1'b1; tick(2);
    chk(soe_a === 1'b0 && soe_b === 1'b0, "R9 status cleared", {soe_a, soe_b}, 0);
    cs_low(20);

    // R3: disable, then fill is ignored
    send(2'b00, 6'b000000, 0, 16'h0);
    cs_low(20);
    send(2'b00, 6'b011010, 16, 16'hBEEF);
    cs_low(250); cs = 1'b1; tick(2);
    chk(soe_a === 1'b0 && soe_b === 1'b0, "R3 no cycle when disabled", {soe_a, soe_b}, 0);
    cs_low(20);
    check_fill(16'h1234, 16'h1234, "R3 array unchanged");

    // R6: chip select falls before the last data bit
    send(2'b00, 6'b110000, 0, 16'h0);
    cs_low(20);
    send(2'b00, 6'b010000, 8, 16'h9999);
    cs_low(250);
    check_fill(16'h1234, 16'h1234, "R6 aborted frame");

    // R7 vs R6: keep chip select high after the last bit
    send(2'b00, 6'b010000, 16, 16'h5A5A);
    tick(95);
    rd_addr = 6'd63; @(negedge clk);
    chk(rd_b === 16'hFFFF, "R2 erased before program", rd_b, 16'hFFFF);
    chk(rd_a === 16'h1234, "R6 no trigger while cs high", rd_a, 16'h1234);
    rd_addr = 6'd0; @(negedge clk);
    chk(rd_b === 16'h5A5A, "R2 program follows erase", rd_b, 16'h5A5A);
    tick(150);
    rd_addr = 6'd17; @(negedge clk);
    chk(rd_b === 16'h5A5A, "R7 clk trigger without further clocks", rd_b, 16'h5A5A);
    chk(rd_a === 16'h1234, "R6 cs trigger still pending", rd_a, 16'h1234);
    cs_low(20); cs = 1'b1; tick(2);
    chk(soe_a === 1'b1 && so_a === 1'b0, "R6 cs fall starts cycle", {so_a, soe_a}, 2'b01);
    chk(soe_b === 1'b1 && so_b === 1'b1, "R7 already ready", {so_b, soe_b}, 2'b11);
    tick(250);
    cs_low(20);
    check_fill(16'h5A5A, 16'h5A5A, "R1 second pattern");
    rd_addr = 6'd9; @(negedge clk);
    chk(rd_a === 16'h5A5A, "R11 read one clock after address", rd_a, 16'h5A5A);

    // R8 boundary on low time
    cs = 1'b1; tick(2);
    cs_low(12); cs = 1'b1; tick(2);
    chk(soe_a === 1'b0, "R8 low time 12 too short", soe_a, 0);
    cs_low(13); cs = 1'b1; tick(2);
    chk(soe_a === 1'b1 && so_a === 1'b1, "R8 low time 13 shows ready", {so_a, soe_a}, 2'b11);
    cs_low(20);

    // R10: disable sent while busy is ignored
    send(2'b00, 6'b010000, 16, 16'h0F0F);
    cs_low(3);
    send(2'b00, 6'b000000, 0, 16'h0);
    cs_low(3);
    tick(300);
    send(2'b00, 6'b010101, 16, 16'h3C3C);
    cs_low(250);
    check_fill(16'h3C3C, 16'h3C3C, "R10 enable survived busy frame");

    run_cmp = 1'b0;
    finish_run();
  end
endmodule